// File: doc/BRIEF.md
# RTC Interrupt Status Register

This block holds the interrupt status of a real-time clock. Three event sources feed it: the selected tap of the clock divider, the alarm comparator and the end of the update cycle. Each source has its own sticky flag. A flag latches its event whatever the state of its enable bit. A summary bit is the OR of every flag whose enable is set, and it drives an active-low interrupt line.

The host reads an 8-bit status byte. The read strobe clears all flags at the clock edge that ends the read cycle. The byte presented during that cycle still shows the values from before the clear. An event that lands in the same cycle as the read is kept, so no event can be lost between a read and the clear that follows it. The register has no write path. An active-low reset clears every flag at once.

Top module: `rtc_irq_status`

## Requirements
- R1: The status byte `rd_data` carries the summary bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3 down to 0 always read zero.
- R2: The periodic flag sets at the first clock edge at which `tap_level` is high after being low at the previous edge. A tap level held high does not set the flag again, and a falling tap level never sets it.
- R3: The alarm flag and the update flag each set at a clock edge at which their pulse input (`alarm_hit`, `update_done`) is high.
- R4: Every flag latches its event even when its enable input is low. Raising the enable later takes effect on the summary bit in the same cycle, without a new event.
- R5: The summary bit equals (periodic & en_periodic) | (alarm & en_alarm) | (update & en_update). It follows the enable inputs combinationally.
- R6: `irq_n` is the inverse of the summary bit: it is low exactly when the summary bit is one.
- R7: While `rd_stb` is high, `rd_data` shows the flags as they stand. At the clock edge that ends that cycle, all flags whose event is not active at that edge are cleared.
- R8: An event that is active at the same edge as a read leaves its flag set after that edge.
- R9: With `rst_n` low, all three flags are zero and `irq_n` is high, from the moment reset asserts, independent of the clock.
- R10: Without a read, a reset or a new event, every flag keeps its value from one edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all flags |
| tap_level | input | 1 | Level of the selected divider tap; a rising edge is the periodic event |
| alarm_hit | input | 1 | Alarm-match pulse, one clock wide or longer |
| update_done | input | 1 | Update-cycle-end pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| rd_stb | input | 1 | Status read strobe; clears the flags at the end of its cycle |
| rd_data | output | 8 | Status byte: summary, periodic, alarm, update, four zero bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each flag is due one clock edge after its event is sampled. The periodic flag needs a low-to-high tap step between two edges, while the other two flags respond to a pulse that is high at the edge. The summary bit and `irq_n` respond to the enables in the same cycle, and a read shows the pre-clear byte during its own cycle and the cleared byte after the edge that ends it. The bench changes every input on the falling clock edge and samples on the next falling edge. Each check therefore sees exactly one rising edge, or none for the combinational enable and reset paths.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int STAT_W  = 8;
  localparam int NUM_SRC = 3;
  // source order inside the flag vector
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;
  // bit positions in the status byte; host software decodes these
  localparam int BIT_SUM = 7;
  localparam int BIT_LO  = 4;  // flags occupy BIT_LO .. BIT_LO+NUM_SRC-1
  // which sources are level inputs that need an edge detector
  localparam logic [NUM_SRC-1:0] EDGE_SRC = 3'b100;
endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  input  logic clr,
  output logic flag
);
  logic hit;

  generate
    if (EDGE) begin : g_edge
      logic ev_q;
      always_ff @(posedge clk) ev_q <= ev_in;
      assign hit = ev_in & ~ev_q;
    end else begin : g_level
      assign hit = ev_in;
    end
  endgenerate

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | hit;
  end
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         sum
);
  assign sum = |(flags & enables);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_level,
  input  logic              alarm_hit,
  input  logic              update_done,
  input  logic              en_periodic,
  input  logic              en_alarm,
  input  logic              en_update,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq_n
);
  logic [NUM_SRC-1:0] ev_vec, en_vec, flag_vec;
  logic               sum_bit;

  always_comb begin
    ev_vec          = '0;
    ev_vec[SRC_PER] = tap_level;
    ev_vec[SRC_ALM] = alarm_hit;
    ev_vec[SRC_UPD] = update_done;
    en_vec          = '0;
    en_vec[SRC_PER] = en_periodic;
    en_vec[SRC_ALM] = en_alarm;
    en_vec[SRC_UPD] = en_update;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      rtc_flag_cell #(.EDGE(EDGE_SRC[i])) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .ev_in(ev_vec[i]),
        .clr  (rd_stb),
        .flag (flag_vec[i])
      );
    end
  endgenerate

  rtc_irq_summary #(.N(NUM_SRC)) u_sum (
    .flags  (flag_vec),
    .enables(en_vec),
    .sum    (sum_bit)
  );

  always_comb begin
    rd_data                            = '0;
    rd_data[BIT_SUM]                   = sum_bit;
    rd_data[BIT_LO +: NUM_SRC]         = flag_vec;
  end

  assign irq_n = ~sum_bit;
endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tap_level,
  input logic       alarm_hit,
  input logic       update_done,
  input logic       en_periodic,
  input logic       en_alarm,
  input logic       en_update,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic       irq_n
);
  // R1
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'h0);

  // R5
  summary_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == ((rd_data[6] & en_periodic) | (rd_data[5] & en_alarm) | (rd_data[4] & en_update)));

  // R6
  irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !((rd_data[6] & en_periodic) | (rd_data[5] & en_alarm) | (rd_data[4] & en_update)));

  // R2
  tap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tap_level) |=> rd_data[6]);

  // R3
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> rd_data[5]);

  // R3
  update_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> rd_data[4]);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !alarm_hit && !update_done) |=> (rd_data[5:4] == 2'b00));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !alarm_hit && !update_done) |=> $stable(rd_data[5:4]));
endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tap_level  (tap_level),
  .alarm_hit  (alarm_hit),
  .update_done(update_done),
  .en_periodic(en_periodic),
  .en_alarm   (en_alarm),
  .en_update  (en_update),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .irq_n      (irq_n)
);

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_level = 1'b0, alarm_hit = 1'b0, update_done = 1'b0;
  logic en_periodic = 1'b0, en_alarm = 1'b0, en_update = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rtc_irq_status uut (
    .clk(clk), .rst_n(rst_n), .tap_level(tap_level), .alarm_hit(alarm_hit),
    .update_done(update_done), .en_periodic(en_periodic), .en_alarm(en_alarm),
    .en_update(en_update), .rd_stb(rd_stb), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {rd_data, irq_n} from flags {p,a,u} and enables {p,a,u}
  function automatic logic [8:0] model(input logic [2:0] f, input logic [2:0] e);
    logic s;
    s = |(f & e);
    return {s, f, 4'h0, ~s};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_en(input logic [2:0] e);
    {en_periodic, en_alarm, en_update} = e;
  endtask

  task automatic clear_read();
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
  endtask

  // raise selected events for one edge; tap drops again afterwards
  task automatic fire(input logic [2:0] m);
    tap_level = m[2]; alarm_hit = m[1]; update_done = m[0];
    step();
    tap_level = 1'b0; alarm_hit = 1'b0; update_done = 1'b0;
  endtask

  initial begin
    step(); step();
    // R9: held in reset
    chk("R9 reset state", {rd_data, irq_n}, model(3'b000, 3'b000));
    rst_n = 1'b1;
    step();

    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        set_en(e[2:0]);
        clear_read();
        chk("R7 cleared", {rd_data, irq_n}, model(3'b000, e[2:0]));
        fire(m[2:0]);
        // R1 R2 R3 R4 R5 R6
        chk("R5 flags/summary after events", {rd_data, irq_n}, model(m[2:0], e[2:0]));
        step();
        chk("R10 hold", {rd_data, irq_n}, model(m[2:0], e[2:0]));
        rd_stb = 1'b1;
        #1;
        chk("R7 pre-clear read value", {rd_data, irq_n}, model(m[2:0], e[2:0]));
        step();
        rd_stb = 1'b0;
        chk("R7 after read", {rd_data, irq_n}, model(3'b000, e[2:0]));
      end
    end

    // R4: latched while disabled, then enabled
    set_en(3'b000);
    fire(3'b010);
    chk("R4 latched while disabled", {rd_data, irq_n}, model(3'b010, 3'b000));
    set_en(3'b010); #1;
    chk("R4 late enable", {rd_data, irq_n}, model(3'b010, 3'b010));
    set_en(3'b101); #1;
    chk("R6 enable off path", {rd_data, irq_n}, model(3'b010, 3'b101));
    clear_read();

    // R8: read colliding with events
    set_en(3'b111);
    fire(3'b111);
    rd_stb = 1'b1; alarm_hit = 1'b1;
    step();
    rd_stb = 1'b0; alarm_hit = 1'b0;
    chk("R8 event during read kept", {rd_data, irq_n}, model(3'b010, 3'b111));
    rd_stb = 1'b1; update_done = 1'b1; tap_level = 1'b1;
    step();
    rd_stb = 1'b0; update_done = 1'b0;
    chk("R8 update and tap during read", {rd_data, irq_n}, model(3'b101, 3'b111));

    // R2: tap held high gives no new flag; falling edge gives none
    clear_read();
    step(); step();
    chk("R2 held tap no re-set", {rd_data, irq_n}, model(3'b000, 3'b111));
    tap_level = 1'b0;
    step();
    chk("R2 falling tap no set", {rd_data, irq_n}, model(3'b000, 3'b111));
    tap_level = 1'b1; step(); tap_level = 1'b0;
    chk("R2 new rising edge", {rd_data, irq_n}, model(3'b100, 3'b111));

    // R9: asynchronous reset mid-run
    fire(3'b011);
    #1 rst_n = 1'b0; #1;
    chk("R9 async clear", {rd_data, irq_n}, model(3'b000, 3'b111));
    step();
    rst_n = 1'b1;
    step();
    chk("R9 stays clear after release", {rd_data, irq_n}, model(3'b000, 3'b111));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule